// File: doc/BRIEF.md
# Multi-channel DMA request arbiter

This block decides which DMA channel the transfer engine serves next. Each channel can be asked for service by a peripheral request line or by a write-one software request. The channel takes part only when the global controller enable is on and its own channel enable bit is set. A per-channel mask bit blocks the peripheral line but never a software request. A software request is kept pending until that channel is granted.

Each channel sits at one of two priority levels. Any eligible high-level channel beats every eligible default-level channel. Within one level, the lowest channel number wins. In every cycle where the engine is not busy and at least one channel is eligible, the block registers a grant. The grant is given three ways: a one-hot vector, an encoded index, and the primary/alternate-select bit of the winning channel.

The per-channel enable, mask, priority and alternate-select bits each have their own set and clear write ports. The global enable has a write strobe with a data bit. The block also turns the engine's completion report into a one-cycle per-channel done strobe. The data movement and the descriptors belong to the engine, not to this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, the global enable is 0. Every channel enable, mask, high-priority and alternate-select bit is 0. No software request is pending, `grant_valid` is 0, and `grant_onehot`, `grant_idx`, `grant_alt` and `done_pulse` are all zero.
- R2: A channel is granted only if, in the cycle before the grant, the global enable was 1 and that channel's enable bit was 1.
- R3: When any eligible channel has its high-priority bit at 1, the grant goes to a channel whose high-priority bit is 1.
- R4: Among eligible channels at the winning level, the grant goes to the lowest channel number.
- R5: A channel whose mask bit is 1 does not treat its `periph_req` line as a request. With the mask bit at 0, a high `periph_req` makes the channel eligible.
- R6: A one-cycle pulse on a `sw_req` bit makes that channel eligible from the next cycle on, whatever its mask bit. The request stays pending until the channel is granted and is cleared by that grant.
- R7: For the enable, mask, high-priority and alternate-select banks, a 1 on a set port bit sets the stored bit in the next cycle, and a 1 on a clear port bit clears it. A 0 on either port leaves the bit unchanged. If set and clear are both 1 for the same bit, clear wins.
- R8: A grant is registered at a clock edge only when `eng_busy` is 0 and some channel is eligible. `grant_valid` is then 1 for that cycle. `grant_onehot` has exactly the bit of the winner set, and `grant_idx` is its number. `grant_alt` is its alternate-select bit. When there is no grant, all four are 0.
- R9: When `eng_done` is 1 with `eng_done_idx` below the channel count, `done_pulse` has only that channel's bit set in the next cycle, for one cycle. An index at or above the channel count gives an all-zero `done_pulse`.
- R10: When `ctrl_en_wr` is 1, `ctrl_en_val` is loaded into the global enable in the next cycle. Otherwise the global enable holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en_wr | input | 1 | Write strobe for the global enable |
| ctrl_en_val | input | 1 | Value written to the global enable |
| chan_en_set | input | NUM_CH | Write-one-to-set for channel enables |
| chan_en_clr | input | NUM_CH | Write-one-to-clear for channel enables |
| req_mask_set | input | NUM_CH | Write-one-to-set for peripheral request masks |
| req_mask_clr | input | NUM_CH | Write-one-to-clear for peripheral request masks |
| hi_pri_set | input | NUM_CH | Write-one-to-set for high-priority bits |
| hi_pri_clr | input | NUM_CH | Write-one-to-clear for high-priority bits |
| alt_sel_set | input | NUM_CH | Write-one-to-set for alternate-select bits |
| alt_sel_clr | input | NUM_CH | Write-one-to-clear for alternate-select bits |
| sw_req | input | NUM_CH | Write-one software request pulses |
| periph_req | input | NUM_CH | Peripheral request lines |
| eng_busy | input | 1 | Engine busy; no grant is issued while it is 1 |
| eng_done | input | 1 | Engine reports completion of a channel |
| eng_done_idx | input | IDX_W | Number of the completed channel |
| ctrl_en_q | output | 1 | Stored global enable |
| chan_en_q | output | NUM_CH | Stored channel enables |
| req_mask_q | output | NUM_CH | Stored peripheral request masks |
| hi_pri_q | output | NUM_CH | Stored high-priority bits |
| alt_sel_q | output | NUM_CH | Stored alternate-select bits |
| grant_valid | output | 1 | A grant is issued this cycle |
| grant_onehot | output | NUM_CH | One-hot grant vector |
| grant_idx | output | IDX_W | Encoded granted channel |
| grant_alt | output | 1 | Alternate-select bit of the granted channel |
| done_pulse | output | NUM_CH | One-cycle per-channel completion strobe |

## Verification
The embedded properties assume the engine holds `eng_busy` and `eng_done` as clean levels at clock edges. They also assume reset is held for at least two edges, so that every value seen one cycle back comes from after reset. The stimulus keeps to these assumptions: it holds reset for three edges and changes every input one time unit after a rising edge. It draws random but sparse set and clear patterns, random `periph_req` and `eng_busy`, and done indices that may fall past the last channel. This exercises the clear-wins case, out-of-range indices and long busy stretches without breaking any stated assumption. The properties make no assumption about how often the engine is busy, or about `sw_req` arriving while a channel is disabled or masked. The stimulus therefore drives both freely.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Largest channel count the index type can carry.
    localparam int MAX_CH = 64;

    typedef logic [$clog2(MAX_CH)-1:0] ch_idx_t;

    typedef enum logic {
        LVL_NORMAL = 1'b0,
        LVL_HIGH   = 1'b1
    } lvl_e;

    // Result of one arbitration pass.
    typedef struct packed {
        logic    valid;
        lvl_e    lvl;
        ch_idx_t idx;
    } pick_t;

    function automatic int idx_width(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dma_arb_setclr.sv
module dma_arb_setclr #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= RST_VAL[i];
            else if (clr_v[i]) q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;
        end
    end

    // R7: a set without a clear leaves the bit at one
    setclr_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

    // R7: any clear leaves the bit at zero
    setclr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(clr_v)) == '0));

    // R7: bits without a write keep their value
    setclr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~$past(set_v | clr_v)) == ($past(q) & ~$past(set_v | clr_v))));

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] elig,
    input  logic [N-1:0] hi_mask,
    output pick_t        pick
);

    logic [N-1:0] hi_cand;
    logic [N-1:0] cand;
    logic         use_hi;

    always_comb begin
        hi_cand = elig & hi_mask;
        use_hi  = |hi_cand;
        cand    = use_hi ? hi_cand : elig;
        pick    = '0;
        pick.lvl = use_hi ? LVL_HIGH : LVL_NORMAL;
        // Scan downward so the lowest set bit is the last one written.
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.valid = 1'b1;
                pick.idx   = ch_idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/dma_arb_done.sv
module dma_arb_done #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_v,
    input  logic [IDX_W-1:0] done_idx,
    output logic [N-1:0]     done_pulse
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N);

    logic in_range;
    assign in_range = ({1'b0, done_idx} < LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_pulse <= '0;
        end else begin
            done_pulse <= '0;
            if (done_v && in_range) done_pulse[done_idx] <= 1'b1;
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(done_pulse) <= 1);

    // R9
    done_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_v || !in_range) |=> (done_pulse == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NUM_CH = 27,
    localparam int IDX_W  = dma_arb_pkg::idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_en_wr,
    input  logic              ctrl_en_val,
    input  logic [NUM_CH-1:0] chan_en_set,
    input  logic [NUM_CH-1:0] chan_en_clr,
    input  logic [NUM_CH-1:0] req_mask_set,
    input  logic [NUM_CH-1:0] req_mask_clr,
    input  logic [NUM_CH-1:0] hi_pri_set,
    input  logic [NUM_CH-1:0] hi_pri_clr,
    input  logic [NUM_CH-1:0] alt_sel_set,
    input  logic [NUM_CH-1:0] alt_sel_clr,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] periph_req,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [IDX_W-1:0]  eng_done_idx,
    output logic              ctrl_en_q,
    output logic [NUM_CH-1:0] chan_en_q,
    output logic [NUM_CH-1:0] req_mask_q,
    output logic [NUM_CH-1:0] hi_pri_q,
    output logic [NUM_CH-1:0] alt_sel_q,
    output logic              grant_valid,
    output logic [NUM_CH-1:0] grant_onehot,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_alt,
    output logic [NUM_CH-1:0] done_pulse
);

    localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

    logic [NUM_CH-1:0] sw_pend;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] pick_oh;
    logic              issue;
    pick_t             pick;

    // Global enable
    always_ff @(posedge clk) begin
        if (rst)             ctrl_en_q <= 1'b0;
        else if (ctrl_en_wr) ctrl_en_q <= ctrl_en_val;
    end

    // Per-channel set/clear banks
    dma_arb_setclr #(.W(NUM_CH)) u_en  (.clk(clk), .rst(rst), .set_v(chan_en_set),
                                        .clr_v(chan_en_clr),  .q(chan_en_q));
    dma_arb_setclr #(.W(NUM_CH)) u_msk (.clk(clk), .rst(rst), .set_v(req_mask_set),
                                        .clr_v(req_mask_clr), .q(req_mask_q));
    dma_arb_setclr #(.W(NUM_CH)) u_pri (.clk(clk), .rst(rst), .set_v(hi_pri_set),
                                        .clr_v(hi_pri_clr),   .q(hi_pri_q));
    dma_arb_setclr #(.W(NUM_CH)) u_alt (.clk(clk), .rst(rst), .set_v(alt_sel_set),
                                        .clr_v(alt_sel_clr),  .q(alt_sel_q));

    // Eligibility: gated by both enables; mask only hides the peripheral line
    always_comb begin
        elig = (periph_req & ~req_mask_q) | sw_pend;
        elig = ctrl_en_q ? (elig & chan_en_q) : '0;
    end

    dma_arb_pick #(.N(NUM_CH)) u_pick (.elig(elig), .hi_mask(hi_pri_q), .pick(pick));

    assign issue   = pick.valid && !eng_busy;
    assign pick_oh = ONE << pick.idx;

    // Software requests pend until granted; a new pulse wins over the clear
    always_ff @(posedge clk) begin
        if (rst) sw_pend <= '0;
        else     sw_pend <= (sw_pend & ~(issue ? pick_oh : '0)) | sw_req;
    end

    // Registered grant
    always_ff @(posedge clk) begin
        if (rst || !issue) begin
            grant_valid  <= 1'b0;
            grant_onehot <= '0;
            grant_idx    <= '0;
            grant_alt    <= 1'b0;
        end else begin
            grant_valid  <= 1'b1;
            grant_onehot <= pick_oh;
            grant_idx    <= pick.idx[IDX_W-1:0];
            grant_alt    <= alt_sel_q[pick.idx];
        end
    end

    dma_arb_done #(.N(NUM_CH), .IDX_W(IDX_W)) u_done (
        .clk(clk), .rst(rst), .done_v(eng_done), .done_idx(eng_done_idx),
        .done_pulse(done_pulse)
    );

    // R8
    no_grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !$past(eng_busy));

    // R8
    grant_shape_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid ? $countones(grant_onehot) == 1 : grant_onehot == '0);

    // R2
    grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ($past(ctrl_en_q) && (($past(chan_en_q) & grant_onehot) != '0)));

    // R3
    hi_level_first_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && (($past(hi_pri_q) & grant_onehot) == '0))
            |-> (($past(elig) & $past(hi_pri_q)) == '0));

    // R4
    lowest_in_level_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (($past(elig)
            & ((($past(hi_pri_q) & grant_onehot) != '0) ? $past(hi_pri_q) : ~$past(hi_pri_q))
            & (grant_onehot - ONE)) == '0));

    // R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(sw_pend) & ~sw_pend) & ~grant_onehot) == '0));

endmodule

// File: tb/dma_req_arbiter_test.sv
`timescale 1ns/1ps
module dma_req_arbiter_test;

    localparam int N  = 27;
    localparam int IW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          ctrl_en_wr, ctrl_en_val;
    logic [N-1:0]  en_s, en_c, mk_s, mk_c, pr_s, pr_c, al_s, al_c, swr, preq;
    logic          busy, edone;
    logic [IW-1:0] edidx;
    logic          o_ctrl;
    logic [N-1:0]  o_en, o_mk, o_pr, o_al, o_goh, o_done;
    logic          o_gv, o_galt;
    logic [IW-1:0] o_gidx;

    dma_req_arbiter #(.NUM_CH(N)) uut (
        .clk(clk), .rst(rst), .ctrl_en_wr(ctrl_en_wr), .ctrl_en_val(ctrl_en_val),
        .chan_en_set(en_s), .chan_en_clr(en_c), .req_mask_set(mk_s), .req_mask_clr(mk_c),
        .hi_pri_set(pr_s), .hi_pri_clr(pr_c), .alt_sel_set(al_s), .alt_sel_clr(al_c),
        .sw_req(swr), .periph_req(preq), .eng_busy(busy), .eng_done(edone),
        .eng_done_idx(edidx), .ctrl_en_q(o_ctrl), .chan_en_q(o_en), .req_mask_q(o_mk),
        .hi_pri_q(o_pr), .alt_sel_q(o_al), .grant_valid(o_gv), .grant_onehot(o_goh),
        .grant_idx(o_gidx), .grant_alt(o_galt), .done_pulse(o_done)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state
    logic         m_ctrl;
    logic [N-1:0] m_en, m_mk, m_pr, m_al, m_pend;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic idle_inputs();
        ctrl_en_wr = 0; ctrl_en_val = 0;
        en_s = '0; en_c = '0; mk_s = '0; mk_c = '0;
        pr_s = '0; pr_c = '0; al_s = '0; al_c = '0;
        swr = '0; preq = '0; busy = 0; edone = 0; edidx = '0;
    endtask

    task automatic model_reset();
        m_ctrl = 0; m_en = '0; m_mk = '0; m_pr = '0; m_al = '0; m_pend = '0;
    endtask

    // One clock: predict, step, compare, update the reference, idle inputs.
    task automatic cycle(input string gtag);
        logic [N-1:0] elig, hi, cand, e_oh, e_done;
        logic         e_gv, e_alt;
        logic [IW-1:0] e_idx;
        int w;
        elig = m_ctrl ? (m_en & ((preq & ~m_mk) | m_pend)) : '0;
        hi   = elig & m_pr;
        cand = (hi != '0) ? hi : elig;
        w    = lowest(cand);
        e_gv = (!busy) && (w >= 0);
        e_oh = e_gv ? (N'(1) << w) : '0;
        e_idx = e_gv ? IW'(w) : '0;
        e_alt = e_gv ? m_al[w] : 1'b0;
        e_done = (edone && edidx < N) ? (N'(1) << edidx) : '0;
        @(posedge clk);
        #1;
        chk(o_gv == e_gv,     gtag, "grant_valid",  64'(o_gv),   64'(e_gv));
        chk(o_goh == e_oh,    gtag, "grant_onehot", 64'(o_goh),  64'(e_oh));
        chk(o_gidx == e_idx,  gtag, "grant_idx",    64'(o_gidx), 64'(e_idx));
        chk(o_galt == e_alt,  "R8", "grant_alt",    64'(o_galt), 64'(e_alt));
        chk(o_done == e_done, "R9", "done_pulse",   64'(o_done), 64'(e_done));
        if (ctrl_en_wr) m_ctrl = ctrl_en_val;
        m_en   = (m_en | en_s) & ~en_c;
        m_mk   = (m_mk | mk_s) & ~mk_c;
        m_pr   = (m_pr | pr_s) & ~pr_c;
        m_al   = (m_al | al_s) & ~al_c;
        m_pend = (m_pend & ~e_oh) | swr;
        chk(o_ctrl == m_ctrl, "R10", "ctrl_en_q",  64'(o_ctrl), 64'(m_ctrl));
        chk(o_en == m_en,     "R7",  "chan_en_q",  64'(o_en),   64'(m_en));
        chk(o_mk == m_mk,     "R7",  "req_mask_q", 64'(o_mk),   64'(m_mk));
        chk(o_pr == m_pr,     "R7",  "hi_pri_q",   64'(o_pr),   64'(m_pr));
        chk(o_al == m_al,     "R7",  "alt_sel_q",  64'(o_al),   64'(m_al));
        idle_inputs();
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5A17_C0DE);
        idle_inputs();
        rst = 1;
        // R1: activity on the inputs during reset must not leave state behind
        en_s = '1; swr = '1; pr_s = '1;
        repeat (3) @(posedge clk);
        #1;
        idle_inputs();
        rst = 0;
        model_reset();
        chk({o_ctrl, o_en, o_mk, o_pr, o_al} == '0, "R1", "state after reset",
            64'({o_en, o_ctrl}), 64'(0));
        chk({o_gv, o_goh, o_gidx, o_galt, o_done} == '0, "R1", "outputs after reset",
            64'(o_goh), 64'(0));
        cycle("R1");
        chk(o_gv == 1'b0, "R1", "no pending software request", 64'(o_gv), 64'(0));

        // R10: global enable on; then enable channels 0 and 26
        ctrl_en_wr = 1; ctrl_en_val = 1; cycle("R10");
        en_s[0] = 1; en_s[26] = 1; cycle("R7");

        // R5: mask channel 0, both lines up -> 26
        mk_s[0] = 1; cycle("R5");
        preq[0] = 1; preq[26] = 1; cycle("R5");
        chk(o_gidx == 26, "R5", "masked line ignored", 64'(o_gidx), 64'(26));
        mk_c[0] = 1; cycle("R5");
        preq[0] = 1; preq[26] = 1; cycle("R4");
        chk(o_gidx == 0, "R4", "lowest number wins", 64'(o_gidx), 64'(0));

        // R3: high level for 26 beats 0
        pr_s[26] = 1; al_s[26] = 1; cycle("R7");
        preq[0] = 1; preq[26] = 1; cycle("R3");
        chk(o_gidx == 26 && o_galt, "R3", "high level wins", 64'(o_gidx), 64'(26));

        // R8: busy blocks any grant
        preq[0] = 1; busy = 1; cycle("R8");
        chk(o_gv == 0, "R8", "no grant while busy", 64'(o_gv), 64'(0));

        // R6: software request on masked channel 26, held across busy cycles
        mk_s[26] = 1; cycle("R7");
        swr[26] = 1; busy = 1; cycle("R6");
        busy = 1; cycle("R6");
        busy = 1; cycle("R6");
        cycle("R6");
        chk(o_gv && o_gidx == 26, "R6", "pending request granted", 64'(o_gidx), 64'(26));
        cycle("R6");
        chk(o_gv == 0, "R6", "pending cleared by grant", 64'(o_gv), 64'(0));

        // R2: disabled channel 5 and global disable
        preq[5] = 1; cycle("R2");
        chk(o_gv == 0, "R2", "disabled channel", 64'(o_gv), 64'(0));
        ctrl_en_wr = 1; ctrl_en_val = 0; cycle("R10");
        preq[0] = 1; cycle("R2");
        chk(o_gv == 0, "R2", "global enable off", 64'(o_gv), 64'(0));

        // R7: set and clear together -> clear wins
        en_s[3] = 1; en_c[3] = 1; cycle("R7");
        chk(o_en[3] == 0, "R7", "clear wins", 64'(o_en[3]), 64'(0));

        // R9: done strobes
        edone = 1; edidx = 4; cycle("R9");
        chk(o_done == (N'(1) << 4), "R9", "done strobe", 64'(o_done), 64'(1 << 4));
        edone = 1; edidx = 31; cycle("R9");
        chk(o_done == '0, "R9", "out of range index", 64'(o_done), 64'(0));

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            ctrl_en_wr  = ($urandom % 40) == 0;
            ctrl_en_val = ($urandom % 6) != 0;
            en_s = N'($urandom & $urandom & $urandom);
            en_c = N'($urandom & $urandom & $urandom & $urandom);
            mk_s = N'($urandom & $urandom & $urandom & $urandom);
            mk_c = N'($urandom & $urandom & $urandom);
            pr_s = N'($urandom & $urandom & $urandom & $urandom);
            pr_c = N'($urandom & $urandom & $urandom & $urandom);
            al_s = N'($urandom & $urandom & $urandom);
            al_c = N'($urandom & $urandom & $urandom);
            swr  = N'($urandom & $urandom & $urandom & $urandom);
            preq = N'($urandom & $urandom & $urandom);
            busy = ($urandom % 3) == 0;
            edone = ($urandom % 2) == 0;
            edidx = IW'($urandom % 32);
            cycle("R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule